// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Write Lock

This block is the slave side of a two-wire serial bus, joined to a 256-byte on-chip memory. It runs on a fast system clock and oversamples the bus clock and data lines. From the sampled lines it finds bus conditions, takes in bytes most significant bit first, and answers a control byte only when that byte carries its device code and its three strapped select bits. The block never drives the data line high. It either pulls it low or lets it go, and the top-level output is that pull-low enable.

A write transfer starts with a word address, which loads the internal byte pointer, and then any number of data bytes. Each data byte is stored and moves the pointer on. A read transfer streams bytes from the pointer onward until the master declines one. A read can also be issued without a preceding address phase. It then starts where the last transfer left the pointer. A strap input locks the memory: writes are still acknowledged on the bus, but the array keeps its contents.

Top module: `twi_mem_slave`

## Requirements
- R1: After a synchronous reset the data line is released (`sda_drive_lo_o` = 0) and the block waits in idle for a bus start.
- R2: A start (data falls while the clock is high) begins reception of a control byte from any state. A stop (data rises while the clock is high) releases the data line and returns the block to idle.
- R3: The control byte arrives most significant bit first. Bits [7:4] must equal 4'b1010 and bits [3:1] must equal `chip_sel_i`; bit 0 set to 1 selects a read. On a match, the data line is held low through the ninth clock. On a mismatch, it stays released and all traffic is ignored until the next start.
- R4: In a write, the first byte after the control byte loads the pointer and is acknowledged. Each following byte is acknowledged, stored at the pointer, and the pointer then advances by one.
- R5: While `wr_lock_i` is 1, data bytes are still acknowledged and the pointer still advances, but the array is left unchanged.
- R6: In a read, the byte at the pointer is sent most significant bit first, with the line pulled low for a 0 bit. The pointer advances after each byte, and a master acknowledge (line low on the ninth clock) starts the next byte.
- R7: A master non-acknowledge (line high on the ninth clock of a read byte) ends the read. The line stays released and the block idles until a start.
- R8: A read control byte that follows no address phase returns data from the pointer value left by the previous transfer.
- R9: The pointer wraps from 255 to 0 in both reads and writes.
- R10: A start received partway through a byte aborts that byte. Its partial bits are not written, and the new control byte is handled normally.
- R11: Outside start and stop, the pull-low enable changes only while the sampled bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| chip_sel_i | input | 3 | Strapped select bits compared with control byte bits [3:1] |
| wr_lock_i | input | 1 | 1 blocks every update of the memory array |
| sda_drive_lo_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The assertions assume a well-behaved master. Each bus clock half-period spans several system clocks, data changes only while the clock is low except to form a start or stop, and the master releases the line on any bit where the slave may drive. Under these assumptions a bus clock edge and a start or stop are never seen in the same system cycle. The bench stays within them by driving the bus with an open-drain model. Every level is held for eight system clocks, each data change waits half that time after the clock falls, and the line is released before every acknowledge and read bit.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam logic [CNT_W-1:0] CNT_ACK = 4'd8;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WRITE,
    ST_READ
  } twi_state_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  // idle bus reads high, so reset to ones to avoid false edges
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/twi_byte_ram.sv
module twi_byte_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int AW        = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_sel_i,
  input  logic       wr_lock_i,
  output logic       sda_drive_lo_o
);
  import twi_pkg::*;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  twi_line_sync #(.STAGES(SYNC_STGS)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  twi_state_t         state;
  logic [CNT_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0]  shreg;
  logic [AW-1:0]      ptr;
  logic [BYTE_W-1:0]  rd_byte;
  logic               mem_we;
  logic               ctrl_hit;
  logic               byte_done;

  assign ctrl_hit  = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == chip_sel_i);
  assign byte_done = (bit_cnt == CNT_ACK);
  assign mem_we    = scl_fall && !start_det && !stop_det &&
                     (state == ST_WRITE) && byte_done && !wr_lock_i;

  twi_byte_ram #(.AW(AW), .DW(BYTE_W)) ram_i (
    .clk  (clk),
    .we   (mem_we),
    .waddr(ptr),
    .wdata(shreg),
    .raddr(ptr),
    .rdata(rd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      bit_cnt        <= '0;
      shreg          <= '0;
      ptr            <= '0;
      sda_drive_lo_o <= 1'b0;
    end else if (start_det) begin
      state          <= ST_CTRL;
      bit_cnt        <= '0;
      sda_drive_lo_o <= 1'b0;
    end else if (stop_det) begin
      state          <= ST_IDLE;
      bit_cnt        <= '0;
      sda_drive_lo_o <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (!byte_done) begin
          if (state != ST_READ) shreg <= {shreg[BYTE_W-2:0], sda_lvl};
          bit_cnt <= bit_cnt + 1'b1;
        end else begin
          // ninth clock high: acknowledge slot closes
          bit_cnt <= '0;
          unique case (state)
            ST_CTRL:  state <= ctrl_hit ? (shreg[0] ? ST_READ : ST_ADDR) : ST_IDLE;
            ST_ADDR:  state <= ST_WRITE;
            ST_READ: begin
              ptr <= ptr + 1'b1;
              if (sda_lvl) state <= ST_IDLE;
            end
            default:  state <= state;
          endcase
        end
      end else if (scl_fall) begin
        if (state == ST_READ) begin
          sda_drive_lo_o <= !byte_done && !rd_byte[~bit_cnt[2:0]];
        end else if (byte_done) begin
          unique case (state)
            ST_CTRL:  sda_drive_lo_o <= ctrl_hit;
            ST_ADDR: begin
              sda_drive_lo_o <= 1'b1;
              ptr            <= shreg[AW-1:0];
            end
            ST_WRITE: begin
              sda_drive_lo_o <= 1'b1;
              ptr            <= ptr + 1'b1;
            end
            default:  sda_drive_lo_o <= 1'b0;
          endcase
        end else begin
          sda_drive_lo_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
  import twi_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_lock_i,
  input logic             sda_drive_lo_o,
  input logic             mem_we,
  input twi_state_t       state,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             start_det,
  input logic             stop_det,
  input logic             scl_lvl
);
  a_r1_reset_release: assert property (@(posedge clk)
    rst |=> (!sda_drive_lo_o && state == ST_IDLE));

  a_r2_start_to_ctrl: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_CTRL && bit_cnt == '0));

  a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_drive_lo_o));

  a_r5_lock_no_write: assert property (@(posedge clk) disable iff (rst)
    wr_lock_i |-> !mem_we);

  a_r7_idle_released: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_drive_lo_o);

  a_r4_bitcnt_range: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_ACK);

  a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_drive_lo_o) && !$past(start_det) && !$past(stop_det))
      |-> !$past(scl_lvl));
endmodule

bind twi_mem_slave twi_mem_slave_chk chk_i (.*);

// File: tb/twi_mem_slave_tb_top.sv
module twi_mem_slave_tb_top;
  localparam int HP = 8;
  localparam logic [3:0] CODE = 4'b1010;
  localparam logic [2:0] CS   = 3'b101;
  localparam int NVEC = 4;
  localparam logic [15:0] VEC [NVEC] = '{16'h0312, 16'h7FA5, 16'hC000, 16'h103C};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic wr_lock = 1'b0;
  logic drv;
  logic sda_bus;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  assign sda_bus = m_sda & ~drv;

  always #2.5 clk = ~clk;

  twi_mem_slave dut_i (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (scl),
    .sda_i         (sda_bus),
    .chip_sel_i    (CS),
    .wr_lock_i     (wr_lock),
    .sda_drive_lo_o(drv)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(HP);
    scl = 1'b1;   tick(HP);
    m_sda = 1'b0; tick(HP);
    scl = 1'b0;   tick(HP);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(HP);
    scl = 1'b1;   tick(HP);
    m_sda = 1'b1; tick(HP);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      m_sda = b[7-i]; tick(HP);
      scl = 1'b1;     tick(HP);
      scl = 1'b0;     tick(HP/2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    put_bits(b, 8);
    m_sda = 1'b1; tick(HP);
    scl = 1'b1;   tick(HP/2);
    ack = !sda_bus;
    tick(HP/2);
    scl = 1'b0;   tick(HP/2);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b, output logic stab);
    logic v1;
    stab = 1'b1;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(HP);
      scl = 1'b1; tick(2);
      v1 = sda_bus; tick(HP-4);
      b[7-i] = sda_bus;
      if (v1 !== sda_bus) stab = 1'b0;
      tick(2);
      scl = 1'b0;
    end
    tick(HP/2);
    m_sda = !mack; tick(HP/2);
    scl = 1'b1;    tick(HP);
    scl = 1'b0;    tick(2);
    m_sda = 1'b1;  tick(HP/2);
  endtask

  task automatic begin_write(input logic [7:0] addr, input string req);
    logic a;
    bus_start();
    send_byte({CODE, CS, 1'b0}, a); chk({req, " ctrl ack"}, {7'd0, a}, 8'd1);
    send_byte(addr, a);             chk({req, " addr ack"}, {7'd0, a}, 8'd1);
  endtask

  task automatic begin_read_at(input logic [7:0] addr, input string req);
    logic a;
    begin_write(addr, req);
    bus_start();
    send_byte({CODE, CS, 1'b1}, a); chk({req, " rd ctrl ack"}, {7'd0, a}, 8'd1);
  endtask

  initial begin
    logic a, st;
    logic [7:0] d;
    tick(5);
    rst = 1'b0;
    tick(4);
    // R1: released after reset
    chk("R1 reset drive", {7'd0, drv}, 8'd0);

    // table of single-byte writes then random reads (R4, R6)
    for (int v = 0; v < NVEC; v++) begin
      begin_write(VEC[v][15:8], "R4");
      send_byte(VEC[v][7:0], a); chk("R4 data ack", {7'd0, a}, 8'd1);
      bus_stop();
      begin_read_at(VEC[v][15:8], "R6");
      recv_byte(1'b0, d, st);    chk("R6 readback", d, VEC[v][7:0]);
      bus_stop();
    end

    // R3: wrong select bits, then wrong device code
    bus_start();
    send_byte({CODE, 3'b100, 1'b0}, a); chk("R3 cs mismatch no ack", {7'd0, a}, 8'd0);
    send_byte(8'h00, a);                chk("R3 ignored after mismatch", {7'd0, a}, 8'd0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, CS, 1'b0}, a);  chk("R3 code mismatch no ack", {7'd0, a}, 8'd0);
    bus_stop();
    chk("R2 released after stop", {7'd0, drv}, 8'd0);

    // R9: sequential write across the wrap
    begin_write(8'hFE, "R9");
    send_byte(8'hA1, a); chk("R4 seq ack 0", {7'd0, a}, 8'd1);
    send_byte(8'hB2, a); chk("R4 seq ack 1", {7'd0, a}, 8'd1);
    send_byte(8'hC3, a); chk("R9 seq ack wrap", {7'd0, a}, 8'd1);
    send_byte(8'hD4, a); chk("R9 seq ack 3", {7'd0, a}, 8'd1);
    bus_stop();
    begin_read_at(8'hFE, "R9");
    recv_byte(1'b1, d, st); chk("R6 seq read 0", d, 8'hA1);
    chk("R11 bits stable while clock high", {7'd0, st}, 8'd1);
    recv_byte(1'b1, d, st); chk("R6 seq read 1", d, 8'hB2);
    recv_byte(1'b0, d, st); chk("R9 read wrapped", d, 8'hC3);
    tick(HP);
    chk("R7 released after nack", {7'd0, drv}, 8'd0);
    bus_stop();

    // R8: current-address read continues at 0x01
    bus_start();
    send_byte({CODE, CS, 1'b1}, a); chk("R8 ctrl ack", {7'd0, a}, 8'd1);
    recv_byte(1'b0, d, st);         chk("R8 current address data", d, 8'hD4);
    bus_stop();

    // R5: locked write acknowledged but not stored
    wr_lock = 1'b1;
    begin_write(8'h10, "R5");
    send_byte(8'h55, a); chk("R5 locked data ack", {7'd0, a}, 8'd1);
    bus_stop();
    wr_lock = 1'b0;
    begin_read_at(8'h10, "R5");
    recv_byte(1'b0, d, st); chk("R5 memory unchanged", d, 8'h3C);
    bus_stop();

    // R10: start in mid-byte aborts the partial data byte
    begin_write(8'h03, "R10");
    put_bits(8'hFF, 4);
    bus_start();
    send_byte({CODE, CS, 1'b0}, a); chk("R10 ctrl after abort", {7'd0, a}, 8'd1);
    send_byte(8'h03, a);            chk("R10 addr after abort", {7'd0, a}, 8'd1);
    bus_start();
    send_byte({CODE, CS, 1'b1}, a); chk("R10 rd ctrl ack", {7'd0, a}, 8'd1);
    recv_byte(1'b0, d, st);         chk("R10 no partial write", d, 8'h12);
    bus_stop();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule